// File: doc/BRIEF.md
# Scoreboard Dynamic Issue Controller

This block is the hazard-tracking controller for a small floating-point pipeline. The pipeline runs fetch, issue, operand read, execute, memory and writeback, and has three functional units: add/subtract, multiply and divide. Each cycle it is offered at most one decoded instruction. An instruction carries a two-bit operation class, a destination register and two source registers. The controller accepts the instruction only when its unit is free and no other in-flight instruction will write the same destination. After that, each unit waits on its own for its source operands. It runs a latency counter in place of a real datapath, passes one memory cycle and then asks to write back.

Instructions may read operands, finish execution and write back in an order other than program order. The controller keeps the program-order result by tracking three hazards. Read-after-write is handled in the operand-read wait. Write-after-write is handled at issue. Write-after-read is handled by holding a writeback while an older instruction has not yet read the register's old value. The register file holds 16 entries of 32 bits and takes one write per cycle. A placeholder function of the two operands stands in for each arithmetic result, so the results can be checked.

The stage-advance outputs mark when each unit reads its operands and when it finishes executing. The writeback port shows which unit writes, to which register, and what value.

Top module: `sbc_issue_ctrl`

## Requirements
- R1: Once reset has been released and synchronized, every unit is idle, `in_ready` is high, `wb_valid` is low and `read_fire` is zero. Register i holds the value i.
- R2: An instruction is issued in a cycle where `in_valid` and `in_ready` are both high. Op code 0 (add) and op code 1 (sub) go to unit 0, op code 2 (mul) to unit 1 and op code 3 (div) to unit 2. `in_ready` is low while the target unit is busy. If the sources have no pending writer, `read_fire[unit]` pulses in the cycle after issue.
- R3: `in_ready` is low while any in-flight instruction has the same destination register, so there is never more than one pending write per register.
- R4: A source that has a pending writer is read no earlier than the cycle after that writer's writeback. An instruction waiting for operands does not block a later independent instruction on another unit.
- R5: `exec_done[unit]` pulses exactly 2 (unit 0), 3 (unit 1) or 5 (unit 2) cycles after that unit's `read_fire`.
- R6: A later instruction on a faster unit may write back before an earlier, slower one.
- R7: A unit's writeback is held while another unit is waiting to read the destination register's current value, that is, a source ready but not yet read. It proceeds in the cycle after that read.
- R8: At most one writeback occurs per cycle, and the lower unit number wins. A writeback comes no earlier than two cycles after `exec_done`. The unit can accept a new instruction in the cycle after its writeback.
- R9: The result, with a = value of src1 and b = value of src2 at operand read, is a+b for op 0, a-b for op 1, the low 32 bits of a*b for op 2, and a XOR b for op 3.
- R10: After all instructions drain, the register file matches executing the instruction stream one at a time in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Decoded instruction offered |
| in_op | input | 2 | Operation class: 0 add, 1 sub, 2 mul, 3 div |
| in_dst | input | 4 | Destination register |
| in_src1 | input | 4 | First source register |
| in_src2 | input | 4 | Second source register |
| in_ready | output | 1 | Instruction is issued this cycle if offered |
| read_fire | output | 3 | Per-unit operand-read stage advance |
| exec_done | output | 3 | Per-unit last execute cycle |
| wb_valid | output | 1 | Register-file write this cycle |
| wb_unit | output | 2 | Unit performing the write |
| wb_reg | output | 4 | Register written |
| wb_data | output | 32 | Value written |

## Verification
The assertions assume the instruction fields are stable and meaningful only while `in_valid` is high. They also assume that an offered instruction stays offered until `in_ready` accepts it, so the checker only reasons about accepted issues. The stimulus holds each instruction until it is accepted and drops `in_valid` right after the accepting edge. It never offers an instruction during reset. Directed sequences create each hazard on purpose: slow divide against fast multiply on one destination, a dependent add, and an anti-dependent multiply. A seeded random stream then mixes all four op classes over the whole register file.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int NUM_FU = 3;
  localparam int FU_W   = 2;

  typedef logic [FU_W-1:0] fu_id_t;
  localparam fu_id_t FU_NONE = 2'd3;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPS,
    ST_EXEC,
    ST_MEM,
    ST_WBR
  } fu_st_e;

  function automatic fu_id_t fu_of(input op_e op);
    case (op)
      OP_ADD, OP_SUB: fu_of = 2'd0;
      OP_MUL:         fu_of = 2'd1;
      default:        fu_of = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/sbc_rst_sync.sv
module sbc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_ns <= meta_q;
    end
  end
endmodule

// File: rtl/sbc_reg_state.sv
module sbc_reg_state
  import sbc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           iss_en,
  input  logic [REG_W-1:0]               iss_dst,
  input  fu_id_t                         iss_fu,
  input  logic                           wb_valid,
  input  logic [REG_W-1:0]               wb_reg,
  input  logic [DATA_W-1:0]              wb_data,
  output logic [NREG-1:0][DATA_W-1:0]    rf_q,
  output logic [NREG-1:0][FU_W-1:0]      owner_q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic              wr_hit;
    logic              iss_hit;
    logic              own_en;
    logic [FU_W-1:0]   own_d;

    always_comb begin
      wr_hit  = wb_valid && (wb_reg == REG_W'(i));
      iss_hit = iss_en && (iss_dst == REG_W'(i));
      own_en  = wr_hit || iss_hit;
      own_d   = owner_q[i];
      if (wr_hit)  own_d = FU_NONE;
      if (iss_hit) own_d = iss_fu;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rf_q[i]    <= DATA_W'(i);
        owner_q[i] <= FU_NONE;
      end else begin
        if (wr_hit) rf_q[i]    <= wb_data;
        if (own_en) owner_q[i] <= own_d;
      end
    end
  end
endmodule

// File: rtl/sbc_wb_arb.sv
module sbc_wb_arb #(
  parameter int N     = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any   = |req;
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
    if (any) grant[idx] = 1'b1;
  end
endmodule

// File: rtl/sbc_fu_slot.sv
module sbc_fu_slot
  import sbc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  parameter int LAT    = 2,
  localparam int REG_W = $clog2(NREG),
  localparam int CNT_W = $clog2(LAT + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        iss_en,
  input  op_e                         iss_op,
  input  logic [REG_W-1:0]            iss_dst,
  input  logic [REG_W-1:0]            iss_s1,
  input  logic [REG_W-1:0]            iss_s2,
  input  fu_id_t                      iss_q1,
  input  fu_id_t                      iss_q2,
  input  logic                        wb_valid,
  input  fu_id_t                      wb_unit,
  input  logic                        wb_grant,
  input  logic                        war_hold,
  input  logic [NREG-1:0][DATA_W-1:0] rf_q,
  output logic                        busy,
  output logic [REG_W-1:0]            dst_o,
  output logic [REG_W-1:0]            s1_o,
  output logic [REG_W-1:0]            s2_o,
  output logic                        want1_o,
  output logic                        want2_o,
  output logic                        wb_req,
  output logic [DATA_W-1:0]           res_o,
  output logic                        rd_fire,
  output logic                        ex_done
);
  fu_st_e             st_q,  st_d;
  op_e                op_q,  op_d;
  logic [REG_W-1:0]   dst_q, dst_d;
  logic [REG_W-1:0]   s1_q,  s1_d;
  logic [REG_W-1:0]   s2_q,  s2_d;
  fu_id_t             q1_q,  q1_d;
  fu_id_t             q2_q,  q2_d;
  logic               r1_q,  r1_d;
  logic               r2_q,  r2_d;
  logic [DATA_W-1:0]  a_q,   a_d;
  logic [DATA_W-1:0]  b_q,   b_d;
  logic [DATA_W-1:0]  res_q, res_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [DATA_W-1:0]  calc;

  always_comb begin
    case (op_q)
      OP_ADD:  calc = a_q + b_q;
      OP_SUB:  calc = a_q - b_q;
      OP_MUL:  calc = a_q * b_q;
      default: calc = a_q ^ b_q;
    endcase
  end

  always_comb begin
    st_d  = st_q;
    op_d  = op_q;
    dst_d = dst_q;
    s1_d  = s1_q;
    s2_d  = s2_q;
    q1_d  = q1_q;
    q2_d  = q2_q;
    r1_d  = r1_q;
    r2_d  = r2_q;
    a_d   = a_q;
    b_d   = b_q;
    res_d = res_q;
    cnt_d = cnt_q;
    rd_fire = (st_q == ST_OPS) && r1_q && r2_q;
    ex_done = (st_q == ST_EXEC) && (cnt_q == '0);
    case (st_q)
      ST_IDLE: begin
        if (iss_en) begin
          st_d  = ST_OPS;
          op_d  = iss_op;
          dst_d = iss_dst;
          s1_d  = iss_s1;
          s2_d  = iss_s2;
          q1_d  = iss_q1;
          q2_d  = iss_q2;
          r1_d  = (iss_q1 == FU_NONE) || (wb_valid && (wb_unit == iss_q1));
          r2_d  = (iss_q2 == FU_NONE) || (wb_valid && (wb_unit == iss_q2));
        end
      end
      ST_OPS: begin
        if (!r1_q && wb_valid && (wb_unit == q1_q)) r1_d = 1'b1;
        if (!r2_q && wb_valid && (wb_unit == q2_q)) r2_d = 1'b1;
        if (rd_fire) begin
          a_d   = rf_q[s1_q];
          b_d   = rf_q[s2_q];
          cnt_d = CNT_W'(LAT - 1);
          st_d  = ST_EXEC;
        end
      end
      ST_EXEC: begin
        if (ex_done) begin
          res_d = calc;
          st_d  = ST_MEM;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_MEM: st_d = ST_WBR;
      default: begin
        if (wb_grant) st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      op_q  <= OP_ADD;
      dst_q <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
      q1_q  <= FU_NONE;
      q2_q  <= FU_NONE;
      r1_q  <= 1'b0;
      r2_q  <= 1'b0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      r1_q <= r1_d;
      r2_q <= r2_d;
      if (iss_en) begin
        op_q  <= op_d;
        dst_q <= dst_d;
        s1_q  <= s1_d;
        s2_q  <= s2_d;
        q1_q  <= q1_d;
        q2_q  <= q2_d;
      end
      if (rd_fire) begin
        a_q <= a_d;
        b_q <= b_d;
      end
      if (ex_done) res_q <= res_d;
      if (st_q == ST_OPS || st_q == ST_EXEC) cnt_q <= cnt_d;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign dst_o   = dst_q;
  assign s1_o    = s1_q;
  assign s2_o    = s2_q;
  assign want1_o = (st_q == ST_OPS) && r1_q;
  assign want2_o = (st_q == ST_OPS) && r2_q;
  assign wb_req  = (st_q == ST_WBR) && !war_hold;
  assign res_o   = res_q;
endmodule

// File: rtl/sbc_issue_ctrl.sv
module sbc_issue_ctrl
  import sbc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NREG    = 16,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 3,
  parameter int LAT_DIV = 5,
  localparam int REG_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [REG_W-1:0]  in_src1,
  input  logic [REG_W-1:0]  in_src2,
  output logic              in_ready,
  output logic [NUM_FU-1:0] read_fire,
  output logic [NUM_FU-1:0] exec_done,
  output logic              wb_valid,
  output logic [FU_W-1:0]   wb_unit,
  output logic [REG_W-1:0]  wb_reg,
  output logic [DATA_W-1:0] wb_data
);
  logic                              rst_ns;
  logic [NREG-1:0][DATA_W-1:0]       rf_q;
  logic [NREG-1:0][FU_W-1:0]         owner_q;
  logic [NUM_FU-1:0]                 fu_busy;
  logic [NUM_FU:0]                   busy_ext;
  logic [NUM_FU-1:0][REG_W-1:0]      fu_dst;
  logic [NUM_FU-1:0][REG_W-1:0]      fu_s1;
  logic [NUM_FU-1:0][REG_W-1:0]      fu_s2;
  logic [NUM_FU-1:0]                 fu_want1;
  logic [NUM_FU-1:0]                 fu_want2;
  logic [NUM_FU-1:0]                 fu_wb_req;
  logic [NUM_FU-1:0][DATA_W-1:0]     fu_res;
  logic [NUM_FU-1:0]                 war_hold;
  logic [NUM_FU-1:0]                 wb_grant;
  logic [FU_W-1:0]                   wb_idx;
  op_e                               iss_op;
  fu_id_t                            iss_fu;
  fu_id_t                            iss_q1;
  fu_id_t                            iss_q2;
  logic                              iss_en;

  sbc_rst_sync i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  // Issue decision: structural hazard on the unit, WAW hazard on the destination
  always_comb begin
    iss_op   = op_e'(in_op);
    iss_fu   = fu_of(iss_op);
    busy_ext = {1'b1, fu_busy};
    iss_q1   = owner_q[in_src1];
    iss_q2   = owner_q[in_src2];
    in_ready = !busy_ext[iss_fu] && (owner_q[in_dst] == FU_NONE);
    iss_en   = in_valid && in_ready && rst_ns;
  end

  // WAR: hold a result while another unit still wants the old register value
  always_comb begin
    war_hold = '0;
    for (int f = 0; f < NUM_FU; f++) begin
      for (int g = 0; g < NUM_FU; g++) begin
        if (g != f) begin
          if ((fu_want1[g] && (fu_s1[g] == fu_dst[f])) ||
              (fu_want2[g] && (fu_s2[g] == fu_dst[f])))
            war_hold[f] = 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
    localparam int LAT_G = (g == 0) ? LAT_ADD : (g == 1) ? LAT_MUL : LAT_DIV;
    sbc_fu_slot #(
      .DATA_W (DATA_W),
      .NREG   (NREG),
      .LAT    (LAT_G)
    ) i_slot (
      .clk      (clk),
      .rst_n    (rst_ns),
      .iss_en   (iss_en && (iss_fu == FU_W'(g))),
      .iss_op   (iss_op),
      .iss_dst  (in_dst),
      .iss_s1   (in_src1),
      .iss_s2   (in_src2),
      .iss_q1   (iss_q1),
      .iss_q2   (iss_q2),
      .wb_valid (wb_valid),
      .wb_unit  (wb_unit),
      .wb_grant (wb_grant[g]),
      .war_hold (war_hold[g]),
      .rf_q     (rf_q),
      .busy     (fu_busy[g]),
      .dst_o    (fu_dst[g]),
      .s1_o     (fu_s1[g]),
      .s2_o     (fu_s2[g]),
      .want1_o  (fu_want1[g]),
      .want2_o  (fu_want2[g]),
      .wb_req   (fu_wb_req[g]),
      .res_o    (fu_res[g]),
      .rd_fire  (read_fire[g]),
      .ex_done  (exec_done[g])
    );
  end

  sbc_wb_arb #(
    .N (NUM_FU)
  ) i_wb_arb (
    .req   (fu_wb_req),
    .grant (wb_grant),
    .any   (wb_valid),
    .idx   (wb_idx)
  );

  assign wb_unit = wb_idx;
  assign wb_reg  = fu_dst[wb_idx];
  assign wb_data = fu_res[wb_idx];

  sbc_reg_state #(
    .DATA_W (DATA_W),
    .NREG   (NREG)
  ) i_reg_state (
    .clk      (clk),
    .rst_n    (rst_ns),
    .iss_en   (iss_en),
    .iss_dst  (in_dst),
    .iss_fu   (iss_fu),
    .wb_valid (wb_valid),
    .wb_reg   (wb_reg),
    .wb_data  (wb_data),
    .rf_q     (rf_q),
    .owner_q  (owner_q)
  );
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker
  import sbc_pkg::*;
#(
  parameter int NREG    = 16,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 3,
  parameter int LAT_DIV = 5,
  localparam int REG_W  = $clog2(NREG)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_FU-1:0]            busy,
  input logic [NUM_FU-1:0]            rd_fire,
  input logic [NUM_FU-1:0]            ex_done,
  input logic [NUM_FU-1:0]            grant,
  input logic                         wb_valid,
  input logic [FU_W-1:0]              wb_unit,
  input logic [REG_W-1:0]             wb_reg,
  input logic [NUM_FU-1:0][REG_W-1:0] dst,
  input logic [NUM_FU-1:0][REG_W-1:0] src1,
  input logic [NUM_FU-1:0][REG_W-1:0] src2
);
  AST_WB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R8

  for (genvar g = 0; g < NUM_FU; g++) begin : g_unit
    localparam int LAT_G = (g == 0) ? LAT_ADD : (g == 1) ? LAT_MUL : LAT_DIV;
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          run_q <= 0;
      else if (rd_fire[g]) run_q <= 1;
      else if (ex_done[g]) run_q <= 0;
      else if (run_q != 0) run_q <= run_q + 1;
    end

    AST_EXEC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      ex_done[g] |-> (run_q == LAT_G)); // R5

    AST_FREE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && (wb_unit == FU_W'(g))) |=> !busy[g]); // R8

    AST_NO_WAR_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && rd_fire[g] && (wb_unit != FU_W'(g))) |->
        ((src1[g] != wb_reg) && (src2[g] != wb_reg))); // R7

    for (genvar h = g + 1; h < NUM_FU; h++) begin : g_pair
      AST_UNIQUE_DST: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[g] && busy[h]) |-> (dst[g] != dst[h])); // R3
    end
  end
endmodule

bind sbc_issue_ctrl sbc_checker #(
  .NREG    (NREG),
  .LAT_ADD (LAT_ADD),
  .LAT_MUL (LAT_MUL),
  .LAT_DIV (LAT_DIV)
) i_sbc_checker (
  .clk      (clk),
  .rst_n    (rst_ns),
  .busy     (fu_busy),
  .rd_fire  (read_fire),
  .ex_done  (exec_done),
  .grant    (wb_grant),
  .wb_valid (wb_valid),
  .wb_unit  (wb_unit),
  .wb_reg   (wb_reg),
  .dst      (fu_dst),
  .src1     (fu_s1),
  .src2     (fu_s2)
);

// File: tb/test_sbc_issue_ctrl.sv
module test_sbc_issue_ctrl;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_op;
  logic [3:0]  in_dst;
  logic [3:0]  in_src1;
  logic [3:0]  in_src2;
  logic        in_ready;
  logic [2:0]  read_fire;
  logic [2:0]  exec_done;
  logic        wb_valid;
  logic [1:0]  wb_unit;
  logic [3:0]  wb_reg;
  logic [31:0] wb_data;

  typedef struct {
    logic [3:0]  r;
    logic [31:0] d;
  } exp_t;

  exp_t        q_add[$];
  exp_t        q_mul[$];
  exp_t        q_div[$];
  logic [31:0] arch[16];
  logic [31:0] obs[16];
  int          last_rd[3];
  int          last_ex[3];
  int          last_wb[3];
  int          cyc;
  int          checks;
  int          fails;
  bit          mon_en;
  bit          done;

  sbc_issue_ctrl i_sbc_issue_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_dst    (in_dst),
    .in_src1   (in_src1),
    .in_src2   (in_src2),
    .in_ready  (in_ready),
    .read_fire (read_fire),
    .exec_done (exec_done),
    .wb_valid  (wb_valid),
    .wb_unit   (wb_unit),
    .wb_reg    (wb_reg),
    .wb_data   (wb_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lat_of(input int u);
    return (u == 0) ? 2 : (u == 1) ? 3 : 5;
  endfunction

  function automatic logic [31:0] model(input logic [1:0] op,
                                        input logic [31:0] a,
                                        input logic [31:0] b);
    case (op)
      2'd0:    return a + b;
      2'd1:    return a - b;
      2'd2:    return a * b;
      default: return a ^ b;
    endcase
  endfunction

  // Monitor: pops expected writebacks per unit and times the stage pulses
  always @(negedge clk) begin
    if (mon_en) begin
      for (int u = 0; u < 3; u++) begin
        if (read_fire[u]) last_rd[u] = cyc;
        if (exec_done[u]) begin
          chk((cyc - last_rd[u]) == lat_of(u), "R5", "execute latency",
              cyc - last_rd[u], lat_of(u));
          last_ex[u] = cyc;
        end
      end
      if (wb_valid) begin
        exp_t e;
        bit   empty;
        int   u;
        u = int'(wb_unit);
        empty = 1'b0;
        case (u)
          0: if (q_add.size() == 0) empty = 1'b1; else e = q_add.pop_front();
          1: if (q_mul.size() == 0) empty = 1'b1; else e = q_mul.pop_front();
          default: if (q_div.size() == 0) empty = 1'b1; else e = q_div.pop_front();
        endcase
        if (empty) begin
          chk(1'b0, "R2", "unexpected writeback from unit", u, -1);
        end else begin
          chk(wb_reg == e.r, "R9", "writeback register", wb_reg, e.r);
          chk(wb_data == e.d, "R9", "writeback value (R4 operand order)", wb_data, e.d);
        end
        chk((cyc - last_ex[u]) >= 2, "R8", "writeback after exec_done",
            cyc - last_ex[u], 2);
        last_wb[u] = cyc;
        obs[wb_reg] = wb_data;
      end
    end
  end

  task automatic issue(input logic [1:0] op, input int d, input int s1, input int s2,
                       output int acc, output bit first_ok);
    exp_t e;
    int   u;
    e.r = 4'(d);
    e.d = model(op, arch[s1], arch[s2]);
    arch[d] = e.d;
    u = (op == 2'd2) ? 1 : (op == 2'd3) ? 2 : 0;
    case (u)
      0: q_add.push_back(e);
      1: q_mul.push_back(e);
      default: q_div.push_back(e);
    endcase
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    in_dst   = 4'(d);
    in_src1  = 4'(s1);
    in_src2  = 4'(s2);
    #1;
    first_ok = in_ready;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    acc = cyc;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while ((q_add.size() + q_mul.size() + q_div.size()) != 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 3000, "R10", "drain completed", t, 3000);
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    report();
  end

  initial begin
    int  a0, a1, a2;
    bit  k0, k1, k2;
    checks   = 0;
    fails    = 0;
    done     = 1'b0;
    mon_en   = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_op    = 2'd0;
    in_dst   = 4'd0;
    in_src1  = 4'd0;
    in_src2  = 4'd0;
    for (int i = 0; i < 16; i++) begin
      arch[i] = 32'(i);
      obs[i]  = 32'(i);
    end
    for (int u = 0; u < 3; u++) begin
      last_rd[u] = 0;
      last_ex[u] = 0;
      last_wb[u] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;
    #1;
    // R1 reset state
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(wb_valid == 1'b0, "R1", "wb_valid after reset", wb_valid, 0);
    chk(read_fire == 3'b000, "R1", "read_fire after reset", read_fire, 0);

    // R2 / R1: isolated add on reset values; R8 timing of its writeback
    issue(2'd0, 1, 2, 3, a0, k0);
    drain();
    chk(k0, "R2", "isolated add accepted at once", k0, 1);
    chk(last_rd[0] == a0 + 1, "R2", "operand read cycle", last_rd[0], a0 + 1);
    chk(last_wb[0] == a0 + 5, "R8", "earliest writeback cycle", last_wb[0], a0 + 5);

    // R2 structural stall and R8 unit reuse after writeback
    issue(2'd1, 5, 1, 4, a0, k0);
    issue(2'd0, 6, 7, 8, a1, k1);
    drain();
    chk(!k1, "R2", "second add stalls on busy unit", k1, 0);
    chk(a1 == a0 + 6, "R8", "unit reissued after writeback", a1, a0 + 6);

    // R3 WAW: slow divide then fast multiply to the same register
    issue(2'd3, 2, 4, 6, a0, k0);
    issue(2'd2, 2, 3, 5, a1, k1);
    drain();
    chk(!k1, "R3", "WAW stall on pending destination", k1, 0);
    chk(a1 == last_wb[2] + 1, "R3", "WAW issue after first write", a1, last_wb[2] + 1);
    chk(obs[2] == arch[2], "R10", "WAW final register", obs[2], arch[2]);

    // R4 RAW with independent later instruction, R6 out-of-order completion
    issue(2'd3, 2, 4, 6, a0, k0);
    issue(2'd0, 10, 2, 8, a1, k1);
    issue(2'd2, 12, 6, 14, a2, k2);
    drain();
    chk(k2, "R4", "independent mul not blocked", k2, 1);
    chk(last_rd[0] == last_wb[2] + 1, "R4", "dependent read after producer",
        last_rd[0], last_wb[2] + 1);
    chk(last_wb[1] < last_wb[0], "R6", "later mul completes first", last_wb[1], last_wb[0]);

    // R7 WAR: mul overwrites a source the waiting add has not yet read
    issue(2'd3, 0, 1, 2, a0, k0);
    issue(2'd0, 3, 0, 5, a1, k1);
    issue(2'd2, 5, 6, 7, a2, k2);
    drain();
    chk(last_wb[1] == last_rd[0] + 1, "R7", "writeback held until old value read",
        last_wb[1], last_rd[0] + 1);

    // R8 writeback priority: mul and add ready in the same cycle
    issue(2'd2, 1, 2, 3, a0, k0);
    issue(2'd0, 4, 5, 6, a1, k1);
    drain();
    chk(last_wb[0] == a1 + 5, "R8", "add wins writeback tie", last_wb[0], a1 + 5);
    chk(last_wb[1] == last_wb[0] + 1, "R8", "mul written next cycle",
        last_wb[1], last_wb[0] + 1);

    // R10 random stream
    void'($urandom(32'd1234));
    for (int n = 0; n < 150; n++) begin
      issue(2'($urandom), int'($urandom % 16), int'($urandom % 16),
            int'($urandom % 16), a0, k0);
    end
    drain();
    for (int i = 0; i < 16; i++) begin
      chk(obs[i] == arch[i], "R10", "final register state", obs[i], arch[i]);
    end
    report();
  end
endmodule